// File: doc/BRIEF.md
# Chained Expansion-Slot Address Assignment

This block is the bus-facing identification front end of a peripheral card on an expansion bus where cards are linked in a chain. Each card has a chain-enable input coming from its neighbour nearer the host and a chain-enable output going to the next card. After reset, only the card whose input is high and whose output is still low takes part in enumeration. It answers a read of I/O port 0 with a fixed 16-bit identification word. It accepts a write to port 0 that assigns it an 8-bit window number.

Once assigned, the card raises its chain-enable output, so the next card can be enumerated. It stops reacting to port 0. It claims only those I/O cycles whose upper address byte equals its window number, and passes the lower byte on as a window offset together with a read or write select. Cycles that no card claims are never acknowledged, which lets the host find the end of the chain by timeout. Bus strobes are active-low and sampled on the block clock.

Top module: `slot_enum_front`

## Requirements
- R1: After reset, `chain_out`, `bus_ack`, `win_sel`, `win_rd` and `win_wr` are low and `bus_rdata` is zero.
- R2: While `chain_in` is low, no cycle is acknowledged. One clock after `chain_in` is low, the assignment is cleared, which makes `chain_out` low. After `chain_in` returns high, port 0 answers the identification word again.
- R3: While `chain_in` is high and the card is unassigned, a read of address 0x0000 is acknowledged with `bus_rdata` = 0x1F29. The high byte 0x1F (decimal 31) is the type and the low byte 0x29 (decimal 41) is the state code. `bus_rdata` is zero whenever `bus_ack` is low.
- R4: A write to address 0x0000 in the unassigned state captures `bus_wdata[7:0]` as the window number, ignoring `bus_wdata[15:8]`. `chain_out` goes high at the same clock edge that raises `bus_ack` for that write.
- R5: Once assigned, reads and writes of port 0 are not acknowledged, return zero data, and leave the window number unchanged.
- R6: Once assigned, a cycle with `bus_addr[15:8]` equal to the window number is acknowledged. While it is acknowledged, `win_sel` is high, `win_off` equals `bus_addr[7:0]`, and exactly one of `win_rd` or `win_wr` is high, matching the strobe.
- R7: Once assigned, a cycle with any other upper address byte is not acknowledged and leaves `win_sel` low.
- R8: For a claimed cycle, `bus_ack` is low during the first clock with the strobe active. It rises at that clock edge, stays high while the strobe stays active, and falls one clock after the strobe is released.
- R9: While unassigned, accesses to any nonzero address are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chain_in | input | 1 | Chain enable from the card nearer the host |
| bus_rd_n | input | 1 | I/O read strobe, active low |
| bus_wr_n | input | 1 | I/O write strobe, active low |
| bus_addr | input | 16 | I/O address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (identification word, else zero) |
| bus_ack | output | 1 | Cycle acknowledge |
| win_sel | output | 1 | A window cycle is in progress |
| win_rd | output | 1 | Window read select |
| win_wr | output | 1 | Window write select |
| win_off | output | 8 | Port offset inside the window |
| chain_out | output | 1 | Chain enable to the next card |

## Verification
Several properties are checked on every cycle. The assignment can only rise after a port-0 write is captured, and it is dropped one clock after `chain_in` falls. The acknowledge never appears without a strobe on the previous clock and always falls after a release. Read data is nonzero only under acknowledge, and a window select implies an assigned card. The exact identification value, the capture of only the low data byte, and the full matching of every upper address byte against the window number can only be shown by the bench's sweeps. The same holds for the ack latency and for enumeration starting again after the chain drops.

// File: rtl/slot_enum_pkg.sv
package slot_enum_pkg;

   typedef enum logic [1:0] {
      CLAIM_NONE = 2'd0,
      CLAIM_ID   = 2'd1,
      CLAIM_WIN  = 2'd2
   } claim_e;

   function automatic logic [15:0] make_id(input int unsigned kind, input int unsigned state);
      return {kind[7:0], state[7:0]};
   endfunction

endpackage

// File: rtl/slot_base_reg.sv
module slot_base_reg #(
   parameter int SEL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chain_in,
   input  logic             cap_en,
   input  logic [SEL_W-1:0] cap_val,
   output logic [SEL_W-1:0] base_q,
   output logic             assigned_q
);

   generate
      if (SEL_W < 1) begin : g_bad_sel
         $error("SEL_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q     <= '0;
         assigned_q <= 1'b0;
      end else if (!chain_in) begin
         base_q     <= '0;
         assigned_q <= 1'b0;
      end else if (cap_en && !assigned_q) begin
         base_q     <= cap_val;
         assigned_q <= 1'b1;
      end
   end

   a_r4_assign_needs_capture: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(assigned_q) |-> $past(cap_en));

   a_r2_cleared_when_chain_low: assert property (@(posedge clk) disable iff (!rst_n)
      !chain_in |=> !assigned_q);

   a_r5_base_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (assigned_q && chain_in) |=> $stable(base_q));

endmodule

// File: rtl/slot_claim_dec.sv
module slot_claim_dec
   import slot_enum_pkg::*;
#(
   parameter int          ADDR_W       = 16,
   parameter int          SEL_W        = 8,
   parameter int unsigned ID_PORT      = 0,
   parameter bit          FULL_ID_DEC  = 1'b1
) (
   input  logic              chain_in,
   input  logic              assigned,
   input  logic [SEL_W-1:0]  base,
   input  logic [ADDR_W-1:0] addr,
   output claim_e            claim
);

   localparam int OFF_W = ADDR_W - SEL_W;

   generate
      if (OFF_W < 1) begin : g_bad_split
         $error("ADDR_W must exceed SEL_W");
      end
   endgenerate

   logic id_hit;
   logic win_hit;

   generate
      if (FULL_ID_DEC) begin : g_full_id
         assign id_hit = (addr == ADDR_W'(ID_PORT));
      end else begin : g_low_id
         assign id_hit = (addr[OFF_W-1:0] == OFF_W'(ID_PORT));
      end
   endgenerate

   assign win_hit = (addr[ADDR_W-1:OFF_W] == base);

   always_comb begin
      claim = CLAIM_NONE;
      if (chain_in) begin
         if (!assigned) begin
            if (id_hit) claim = CLAIM_ID;
         end else if (win_hit) begin
            claim = CLAIM_WIN;
         end
      end
   end

endmodule

// File: rtl/slot_cycle_trk.sv
module slot_cycle_trk
   import slot_enum_pkg::*;
#(
   parameter int OFF_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chain_in,
   input  logic             rd_n,
   input  logic             wr_n,
   input  claim_e           claim,
   input  logic [OFF_W-1:0] off_in,
   output logic             start,
   output claim_e           held_q,
   output logic             wr_q,
   output logic [OFF_W-1:0] off_q,
   output logic             ack
);

   logic strobe_act;
   logic prev_q;

   assign strobe_act = !rd_n || !wr_n;
   assign start      = strobe_act && !prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         held_q <= CLAIM_NONE;
         wr_q   <= 1'b0;
         off_q  <= '0;
      end else begin
         prev_q <= strobe_act;
         if (!strobe_act || !chain_in) begin
            held_q <= CLAIM_NONE;
            wr_q   <= 1'b0;
         end else if (start) begin
            held_q <= claim;
            wr_q   <= !wr_n;
            off_q  <= off_in;
         end
      end
   end

   assign ack = (held_q != CLAIM_NONE);

   a_r8_ack_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> $past(strobe_act));

   a_r8_ack_drops_on_release: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe_act |=> !ack);

   a_r2_no_ack_chain_low: assert property (@(posedge clk) disable iff (!rst_n)
      !chain_in |=> !ack);

endmodule

// File: rtl/slot_enum_front.sv
module slot_enum_front
   import slot_enum_pkg::*;
#(
   parameter int          ADDR_W      = 16,
   parameter int          DATA_W      = 16,
   parameter int          SEL_W       = 8,
   parameter int unsigned ID_KIND     = 31,
   parameter int unsigned ID_STATE    = 41,
   parameter int unsigned ID_PORT     = 0,
   parameter bit          FULL_ID_DEC = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    chain_in,
   input  logic                    bus_rd_n,
   input  logic                    bus_wr_n,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [DATA_W-1:0]       bus_wdata,
   output logic [DATA_W-1:0]       bus_rdata,
   output logic                    bus_ack,
   output logic                    win_sel,
   output logic                    win_rd,
   output logic                    win_wr,
   output logic [ADDR_W-SEL_W-1:0] win_off,
   output logic                    chain_out
);

   localparam int          OFF_W   = ADDR_W - SEL_W;
   localparam logic [15:0] ID_WORD = make_id(ID_KIND, ID_STATE);

   generate
      if (DATA_W < 16) begin : g_bad_data
         $error("DATA_W must hold the 16-bit identification word");
      end
      if (SEL_W > DATA_W) begin : g_bad_sel
         $error("SEL_W cannot exceed DATA_W");
      end
      if (ID_KIND > 255 || ID_STATE > 255) begin : g_bad_id
         $error("identification bytes must fit in 8 bits");
      end
   endgenerate

   logic [SEL_W-1:0] base_q;
   logic             assigned_q;
   claim_e           claim;
   claim_e           held_q;
   logic             start;
   logic             wr_q;
   logic             cap_en;

   slot_base_reg #(.SEL_W(SEL_W)) u_base (
      .clk        (clk),
      .rst_n      (rst_n),
      .chain_in   (chain_in),
      .cap_en     (cap_en),
      .cap_val    (bus_wdata[SEL_W-1:0]),
      .base_q     (base_q),
      .assigned_q (assigned_q)
   );

   slot_claim_dec #(
      .ADDR_W      (ADDR_W),
      .SEL_W       (SEL_W),
      .ID_PORT     (ID_PORT),
      .FULL_ID_DEC (FULL_ID_DEC)
   ) u_dec (
      .chain_in (chain_in),
      .assigned (assigned_q),
      .base     (base_q),
      .addr     (bus_addr),
      .claim    (claim)
   );

   slot_cycle_trk #(.OFF_W(OFF_W)) u_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .chain_in (chain_in),
      .rd_n     (bus_rd_n),
      .wr_n     (bus_wr_n),
      .claim    (claim),
      .off_in   (bus_addr[OFF_W-1:0]),
      .start    (start),
      .held_q   (held_q),
      .wr_q     (wr_q),
      .off_q    (win_off),
      .ack      (bus_ack)
   );

   assign cap_en    = start && !bus_wr_n && (claim == CLAIM_ID);
   assign chain_out = assigned_q;
   assign win_sel   = (held_q == CLAIM_WIN);
   assign win_rd    = win_sel && !wr_q;
   assign win_wr    = win_sel && wr_q;
   assign bus_rdata = (held_q == CLAIM_ID && !wr_q) ? DATA_W'(ID_WORD) : '0;

   a_r3_data_only_under_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata != '0) |-> bus_ack);

   a_r6_window_needs_assign: assert property (@(posedge clk) disable iff (!rst_n)
      win_sel |-> chain_out);

   a_r6_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({win_rd, win_wr}));

   a_r4_chain_rises_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chain_out) |-> bus_ack);

endmodule

// File: tb/slot_enum_front_test.sv
module slot_enum_front_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chain_in = 1'b0;
   logic        bus_rd_n = 1'b1;
   logic        bus_wr_n = 1'b1;
   logic [15:0] bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        bus_ack;
   logic        win_sel;
   logic        win_rd;
   logic        win_wr;
   logic [7:0]  win_off;
   logic        chain_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   slot_enum_front uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .chain_in  (chain_in),
      .bus_rd_n  (bus_rd_n),
      .bus_wr_n  (bus_wr_n),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .bus_ack   (bus_ack),
      .win_sel   (win_sel),
      .win_rd    (win_rd),
      .win_wr    (win_wr),
      .win_off   (win_off),
      .chain_out (chain_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One bus cycle: strobe held for two clocks, sampled at negedges.
   task automatic access(input bit is_wr, input logic [15:0] a, input logic [15:0] d,
                         input bit exp_ack, input logic [15:0] exp_rd, input bit exp_win,
                         input string req);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      if (is_wr) bus_wr_n = 1'b0; else bus_rd_n = 1'b0;
      #1;
      chk({req, " R8 ack low in first cycle"}, {31'd0, bus_ack}, 32'd0);
      @(negedge clk);
      chk({req, " ack"}, {31'd0, bus_ack}, {31'd0, exp_ack});
      chk({req, " rdata"}, {16'd0, bus_rdata}, {16'd0, exp_rd});
      chk({req, " win_sel"}, {31'd0, win_sel}, {31'd0, exp_win});
      if (exp_win) begin
         chk({req, " R6 offset"}, {24'd0, win_off}, {24'd0, a[7:0]});
         chk({req, " R6 dir"}, {30'd0, win_rd, win_wr}, is_wr ? 32'd1 : 32'd2);
      end
      @(negedge clk);
      chk({req, " R8 ack held"}, {31'd0, bus_ack}, {31'd0, exp_ack});
      bus_rd_n = 1'b1;
      bus_wr_n = 1'b1;
      @(negedge clk);
      chk({req, " R8 ack released"}, {31'd0, bus_ack}, 32'd0);
   endtask

   task automatic sweep(input logic [7:0] base);
      for (int hi = 0; hi < 256; hi++) begin
         logic [15:0] a;
         bit hit;
         a   = {hi[7:0], hi[7:0] ^ 8'h33};
         hit = (hi[7:0] == base);
         access(1'b0, a, 16'h0, hit, 16'h0, hit, hit ? "R6 read hit" : "R7 read miss");
         access(1'b1, a, 16'hA5A5, hit, 16'h0, hit, hit ? "R6 write hit" : "R7 write miss");
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 chain_out", {31'd0, chain_out}, 32'd0);
      chk("R1 ack", {31'd0, bus_ack}, 32'd0);
      chk("R1 sel", {29'd0, win_sel, win_rd, win_wr}, 32'd0);
      chk("R1 rdata", {16'd0, bus_rdata}, 32'd0);
      rst_n = 1'b1;

      // chain input low: nothing answers
      access(1'b0, 16'h0000, 16'h0, 1'b0, 16'h0, 1'b0, "R2 id read chain low");
      access(1'b1, 16'h0000, 16'h0042, 1'b0, 16'h0, 1'b0, "R2 id write chain low");
      chk("R2 chain_out stays low", {31'd0, chain_out}, 32'd0);

      chain_in = 1'b1;
      access(1'b0, 16'h0000, 16'h0, 1'b1, 16'h1F29, 1'b0, "R3 id read");
      access(1'b0, 16'h0100, 16'h0, 1'b0, 16'h0, 1'b0, "R9 unassigned read");
      access(1'b1, 16'h0001, 16'h0011, 1'b0, 16'h0, 1'b0, "R9 unassigned write");
      chk("R9 still unassigned", {31'd0, chain_out}, 32'd0);

      // assign window 0x5A; upper data byte must be ignored
      @(negedge clk);
      bus_addr = 16'h0000; bus_wdata = 16'hC35A; bus_wr_n = 1'b0;
      #1 chk("R4 chain_out before edge", {31'd0, chain_out}, 32'd0);
      @(negedge clk);
      chk("R4 chain_out with ack", {30'd0, chain_out, bus_ack}, 32'd3);
      bus_wr_n = 1'b1;
      @(negedge clk);

      access(1'b0, 16'h0000, 16'h0, 1'b0, 16'h0, 1'b0, "R5 port0 read assigned");
      access(1'b1, 16'h0000, 16'h0077, 1'b0, 16'h0, 1'b0, "R5 port0 write assigned");
      sweep(8'h5A);

      // drop the chain: assignment clears, enumeration restarts
      @(negedge clk);
      chain_in = 1'b0;
      @(negedge clk);
      chk("R2 chain_out cleared", {31'd0, chain_out}, 32'd0);
      access(1'b0, 16'h5A10, 16'h0, 1'b0, 16'h0, 1'b0, "R2 window read chain low");
      chain_in = 1'b1;
      access(1'b0, 16'h0000, 16'h0, 1'b1, 16'h1F29, 1'b0, "R2 id again");
      access(1'b1, 16'h0000, 16'hFF01, 1'b1, 16'h0, 1'b0, "R4 reassign");
      chk("R4 chain_out high", {31'd0, chain_out}, 32'd1);
      sweep(8'h01);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule